// File: doc/BRIEF.md
# Wide Block-Scaled Integer Matrix Engine

This block multiplies a small batch of activation rows by a wide set of weight columns. It suits GEMMs whose batch dimension M is small and whose output dimension N is large. Several square output-stationary systolic tiles sit side by side. Each tile is BLEN rows by BLEN columns, and BLEN equals the batch size M. The tiles together cover N = BLEN × NTILE output columns.

Each step of the reduction dimension K delivers two vectors:
- one activation vector with BLEN elements, which shares a single power-of-two exponent;
- one weight vector with N elements, where each tile's slice shares its own exponent.

Elements and their exponents travel together through every tile. Activations move rightwards and weights move downwards. Each processing element adds its scaled integer product to a local accumulator. Scaling is a left shift by the sum of the two exponents.

A start pulse clears all accumulators. The caller then streams K steps and flags the final one. A done pulse marks the cycle from which every result is final.

Top module: `fsa_array`

## Requirements
- R1: While reset is held, done_o and busy_o are 0 and every result in res_o is 0.
- R2: One cycle after a cycle with start_i high, every result in res_o is 0.
- R3: Result (m, n) equals the sum, over the accepted steps, of x[m]·w[n]·2^(ex+ew[t]). Here t = n / BLEN. Elements are EW-bit two's complement and exponents are SEW-bit unsigned. Activation m is at x_elem_i bits m·EW, weight n is at w_elem_i bits n·EW, and the exponent of tile t is at w_exp_i bits t·SEW. The result is a signed AW-bit field at res_o bit offset (m·N + n)·AW, where AW = 2·EW + clog2(KMAX) + 2·(2^SEW − 1).
- R4: done_o is high for exactly one cycle. That cycle starts at the clock edge that comes 2·BLEN − 2 edges after the edge that samples the last step (step_valid_i and step_last_i both high).
- R5: busy_o is high from the edge after the last step is sampled until done_o rises, and busy_o is 0 while done_o is high.
- R6: Cycles with step_valid_i low leave every result unchanged, whatever the element and exponent inputs carry.
- R7: A tile's weight exponent scales only that tile's BLEN output columns.
- R8: With KMAX steps of the most negative elements and the largest exponents, results are exact and do not overflow.
- R9: A new run of steps without a start pulse adds to the results already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears all accumulators |
| step_valid_i | input | 1 | Current step vectors are valid |
| step_last_i | input | 1 | Current valid step is the final one |
| x_elem_i | input | BLEN·EW | Activation elements, one per output row |
| x_exp_i | input | SEW | Shared activation exponent for the step |
| w_elem_i | input | BLEN·NTILE·EW | Weight elements, one per output column |
| w_exp_i | input | NTILE·SEW | One shared weight exponent per tile |
| busy_o | output | 1 | Drain in progress after the last step |
| done_o | output | 1 | One-cycle pulse: all results final |
| res_o | output | BLEN·BLEN·NTILE·AW | Accumulated results, row-major |

## Verification
The assertions assume three things about the inputs:
- start_i is never raised while a step is still travelling through the skew registers or the grid;
- step_last_i is never raised again before done_o;
- no more than KMAX steps fall between two start pulses.

The stimulus meets these by always waiting a full drain window after each last step before pulsing start or beginning a new run. The longest run it sends is exactly KMAX steps.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

  // Accumulator width: full product, growth over kmax terms, and the largest left shift.
  function automatic int acc_width(int ew, int sew, int kmax);
    return 2 * ew + $clog2(kmax) + 2 * ((1 << sew) - 1);
  endfunction

  // Power-of-two scaling: the exponents add and the product is shifted.
  function automatic longint scaled_term(longint a, longint b, int ea, int eb);
    return (a * b) <<< (ea + eb);
  endfunction

endpackage

// File: rtl/fsa_skew.sv
module fsa_skew #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] stage_q [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
      end else begin
        stage_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      end
    end
    assign q_o = stage_q[DEPTH-1];
  end
endmodule

// File: rtl/fsa_pe.sv
module fsa_pe #(
  parameter int EW  = 8,
  parameter int SEW = 2,
  parameter int AW  = 34
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 av_i,
  input  logic signed [EW-1:0] a_i,
  input  logic [SEW-1:0]       ae_i,
  input  logic signed [EW-1:0] w_i,
  input  logic [SEW-1:0]       we_i,
  output logic signed [AW-1:0] acc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_o <= '0;
    else if (clr_i)  acc_o <= '0;
    else if (av_i)   acc_o <= acc_o + AW'(fsa_pkg::scaled_term(longint'(a_i), longint'(w_i),
                                                               int'(ae_i), int'(we_i)));
  end
endmodule

// File: rtl/fsa_tile.sv
module fsa_tile #(
  parameter int BLEN = 4,
  parameter int EW   = 8,
  parameter int SEW  = 2,
  parameter int AW   = 34
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic [BLEN*EW-1:0]        a_i,
  input  logic [BLEN*SEW-1:0]       ae_i,
  input  logic [BLEN-1:0]           av_i,
  input  logic [BLEN*EW-1:0]        w_i,
  input  logic [SEW-1:0]            we_i,
  output logic [BLEN*BLEN*AW-1:0]   acc_o,
  output logic                      live_o
);
  logic [BLEN*EW-1:0]  w_sk;
  logic [BLEN*SEW-1:0] we_sk;
  logic [BLEN*BLEN-1:0] live_bits;

  // Column c of the weight row is delayed by c cycles.
  for (genvar c = 0; c < BLEN; c++) begin : g_wsk
    fsa_skew #(.W(EW + SEW), .DEPTH(c)) u_sk (
      .clk(clk), .rst_n(rst_n),
      .d_i({w_i[c*EW +: EW], we_i}),
      .q_o({w_sk[c*EW +: EW], we_sk[c*SEW +: SEW]})
    );
  end

  for (genvar r = 0; r < BLEN; r++) begin : g_row
    for (genvar c = 0; c < BLEN; c++) begin : g_col
      logic signed [EW-1:0] a_here, w_here;
      logic [SEW-1:0]       ae_here, we_here;
      logic                 av_here;

      if (c == 0) begin : g_hin
        assign a_here  = a_i[r*EW +: EW];
        assign ae_here = ae_i[r*SEW +: SEW];
        assign av_here = av_i[r];
      end else begin : g_hin
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            a_here <= '0; ae_here <= '0; av_here <= 1'b0;
          end else begin
            a_here  <= g_row[r].g_col[c-1].a_here;
            ae_here <= g_row[r].g_col[c-1].ae_here;
            av_here <= g_row[r].g_col[c-1].av_here;
          end
        end
      end

      if (r == 0) begin : g_vin
        assign w_here  = w_sk[c*EW +: EW];
        assign we_here = we_sk[c*SEW +: SEW];
      end else begin : g_vin
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            w_here <= '0; we_here <= '0;
          end else begin
            w_here  <= g_row[r-1].g_col[c].w_here;
            we_here <= g_row[r-1].g_col[c].we_here;
          end
        end
      end

      fsa_pe #(.EW(EW), .SEW(SEW), .AW(AW)) u_pe (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .av_i(av_here),
        .a_i(a_here), .ae_i(ae_here), .w_i(w_here), .we_i(we_here),
        .acc_o(acc_o[(r*BLEN+c)*AW +: AW])
      );
      assign live_bits[r*BLEN+c] = av_here;
    end
  end

  assign live_o = |live_bits;
endmodule

// File: rtl/fsa_ctrl.sv
module fsa_ctrl #(
  parameter int DRAIN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (DRAIN < 1) ? 1 : $clog2(DRAIN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0; done_o <= 1'b0; cnt_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_o <= 1'b0; cnt_q <= '0;
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_o <= 1'b0; done_o <= 1'b1;
        end
      end else if (last_i) begin
        if (DRAIN == 0) done_o <= 1'b1;
        else begin
          busy_o <= 1'b1; cnt_q <= CW'(DRAIN);
        end
      end
    end
  end
endmodule

// File: rtl/fsa_array.sv
module fsa_array #(
  parameter int BLEN  = 4,
  parameter int NTILE = 3,
  parameter int EW    = 8,
  parameter int SEW   = 2,
  parameter int KMAX  = 4096,
  localparam int NCOL = BLEN * NTILE,
  localparam int AW   = fsa_pkg::acc_width(EW, SEW, KMAX)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     step_valid_i,
  input  logic                     step_last_i,
  input  logic [BLEN*EW-1:0]       x_elem_i,
  input  logic [SEW-1:0]           x_exp_i,
  input  logic [NCOL*EW-1:0]       w_elem_i,
  input  logic [NTILE*SEW-1:0]     w_exp_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [BLEN*NCOL*AW-1:0]  res_o
);
  localparam int DRAIN = 2 * BLEN - 2;

  logic [BLEN*EW-1:0]  a_sk;
  logic [BLEN*SEW-1:0] ae_sk;
  logic [BLEN-1:0]     av_sk;
  logic [NTILE-1:0]    tile_live;
  logic                pipe_live;   // some PE accumulates at the coming edge
  logic                last_fire;   // final step sampled at the coming edge

  assign last_fire = step_valid_i & step_last_i;

  // Row r of the activation vector is delayed by r cycles, shared by all tiles.
  for (genvar r = 0; r < BLEN; r++) begin : g_xsk
    fsa_skew #(.W(1 + SEW + EW), .DEPTH(r)) u_sk (
      .clk(clk), .rst_n(rst_n),
      .d_i({step_valid_i, x_exp_i, x_elem_i[r*EW +: EW]}),
      .q_o({av_sk[r], ae_sk[r*SEW +: SEW], a_sk[r*EW +: EW]})
    );
  end

  for (genvar t = 0; t < NTILE; t++) begin : g_tile
    logic [BLEN*BLEN*AW-1:0] acc;
    fsa_tile #(.BLEN(BLEN), .EW(EW), .SEW(SEW), .AW(AW)) u_tile (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i),
      .a_i(a_sk), .ae_i(ae_sk), .av_i(av_sk),
      .w_i(w_elem_i[t*BLEN*EW +: BLEN*EW]), .we_i(w_exp_i[t*SEW +: SEW]),
      .acc_o(acc), .live_o(tile_live[t])
    );
    for (genvar r = 0; r < BLEN; r++) begin : g_r
      for (genvar c = 0; c < BLEN; c++) begin : g_c
        assign res_o[(r*NCOL + t*BLEN + c)*AW +: AW] = acc[(r*BLEN+c)*AW +: AW];
      end
    end
  end

  assign pipe_live = |tile_live;

  fsa_ctrl #(.DRAIN(DRAIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_i(last_fire),
    .busy_o(busy_o), .done_o(done_o)
  );
endmodule

// File: rtl/fsa_array_chk.sv
module fsa_array_chk #(
  parameter int DRAIN = 6,
  parameter int RW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          last_fire,
  input logic          pipe_live,
  input logic          busy_o,
  input logic          done_o,
  input logic [RW-1:0] res_o
);
  logic [15:0] since_q;
  logic        armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0; armed_q <= 1'b0;
    end else if (last_fire) begin
      since_q <= '0; armed_q <= 1'b1;
    end else if (done_o) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      since_q <= since_q + 16'd1;
    end
  end

  a_r4_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (armed_q && since_q == 16'(DRAIN)));
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r5_busy_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> (busy_o || done_o));
  a_r5_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (res_o == '0));
  a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !pipe_live) |=> $stable(res_o));
endmodule

bind fsa_array fsa_array_chk #(.DRAIN(2*BLEN-2), .RW(BLEN*NCOL*AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_fire(last_fire),
  .pipe_live(pipe_live), .busy_o(busy_o), .done_o(done_o), .res_o(res_o)
);

// File: tb/fsa_array_tb_top.sv
module fsa_array_tb_top;
  localparam int BLEN = 4, NTILE = 3, EW = 8, SEW = 2, KMAX = 4096;
  localparam int NCOL = BLEN * NTILE;
  localparam int AW = 2*EW + $clog2(KMAX) + 2*((1 << SEW) - 1);
  localparam int DRAIN = 2*BLEN - 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst_n, start_i, step_valid_i, step_last_i;
  logic [BLEN*EW-1:0] x_elem_i;
  logic [SEW-1:0] x_exp_i;
  logic [NCOL*EW-1:0] w_elem_i;
  logic [NTILE*SEW-1:0] w_exp_i;
  logic busy_o, done_o;
  logic [BLEN*NCOL*AW-1:0] res_o;

  fsa_array #(.BLEN(BLEN), .NTILE(NTILE), .EW(EW), .SEW(SEW), .KMAX(KMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_valid_i(step_valid_i),
    .step_last_i(step_last_i), .x_elem_i(x_elem_i), .x_exp_i(x_exp_i),
    .w_elem_i(w_elem_i), .w_exp_i(w_exp_i), .busy_o(busy_o), .done_o(done_o),
    .res_o(res_o)
  );

  longint mdl [BLEN][NCOL];
  longint exp_q[$];
  longint cyc_q[$];
  longint cyc = 0;
  int checks = 0, errors = 0;

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint res_at(int m, int n);
    logic signed [AW-1:0] v;
    v = res_o[(m*NCOL + n)*AW +: AW];
    return longint'(v);
  endfunction

  // Monitor: pops the scoreboard when the design signals completion.
  always @(negedge clk) begin
    longint ec, e;
    if (rst_n && done_o) begin
      ec = (cyc_q.size() > 0) ? cyc_q.pop_front() : -1;
      chk(cyc == ec, "R4 done timing", cyc, ec);
      chk(busy_o == 1'b0, "R5 busy low at done", longint'(busy_o), 0);
      for (int m = 0; m < BLEN; m++)
        for (int n = 0; n < NCOL; n++) begin
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 0;
          chk(res_at(m, n) == e, "R3 result value", res_at(m, n), e);
        end
    end
  end

  task automatic do_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(res_o == '0, "R2 start clears", longint'(res_o != '0), 0);
    for (int m = 0; m < BLEN; m++)
      for (int n = 0; n < NCOL; n++) mdl[m][n] = 0;
  endtask

  // mode 0 random, 1 extreme (R8), 2 gapped (R6), 3 single tile scaled (R7)
  task automatic run(int k, int mode);
    int xa [BLEN];
    int wa [NCOL];
    int we [NTILE];
    int xe;
    for (int s = 0; s < k; s++) begin
      if (mode == 2) begin
        @(negedge clk);
        step_valid_i = 1'b0; step_last_i = 1'b1;
        x_elem_i = $urandom; w_elem_i = {3{$urandom}}; x_exp_i = 2'd3; w_exp_i = '1;
      end
      @(negedge clk);
      step_valid_i = 1'b1; step_last_i = (s == k-1);
      xe = (mode == 1) ? 3 : (mode == 3) ? 0 : int'($urandom_range(0, 3));
      x_exp_i = SEW'(xe);
      for (int m = 0; m < BLEN; m++) begin
        xa[m] = (mode == 1) ? -128 : int'($urandom_range(0, 255)) - 128;
        x_elem_i[m*EW +: EW] = EW'(xa[m]);
      end
      for (int t = 0; t < NTILE; t++) begin
        we[t] = (mode == 1) ? 3 : (mode == 3) ? ((t == 1) ? 3 : 0) : int'($urandom_range(0, 3));
        w_exp_i[t*SEW +: SEW] = SEW'(we[t]);
      end
      for (int n = 0; n < NCOL; n++) begin
        wa[n] = (mode == 1) ? -128 : int'($urandom_range(0, 255)) - 128;
        w_elem_i[n*EW +: EW] = EW'(wa[n]);
      end
      for (int m = 0; m < BLEN; m++)
        for (int n = 0; n < NCOL; n++)
          mdl[m][n] += longint'(xa[m]) * longint'(wa[n]) * (longint'(1) << (xe + we[n / BLEN]));
      if (s == k-1) cyc_q.push_back(cyc + 1 + DRAIN);
    end
    @(negedge clk);
    step_valid_i = 1'b0; step_last_i = 1'b0;
    chk(busy_o == 1'b1, "R5 busy after last step", longint'(busy_o), 1);
    for (int m = 0; m < BLEN; m++)
      for (int n = 0; n < NCOL; n++) exp_q.push_back(mdl[m][n]);
    repeat (DRAIN + 3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; step_valid_i = 1'b0; step_last_i = 1'b0;
    x_elem_i = '0; x_exp_i = '0; w_elem_i = '0; w_exp_i = '0;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0 && res_o == '0, "R1 reset state",
        longint'({done_o, busy_o, res_o != '0}), 0);
    rst_n = 1'b1;
    do_start();
    // R6: busy inputs with step_valid_i low must not touch any result
    repeat (4) begin
      @(negedge clk);
      x_elem_i = $urandom; w_elem_i = {3{$urandom}}; x_exp_i = 2'd3; w_exp_i = '1;
      step_last_i = 1'b1;
    end
    @(negedge clk); step_last_i = 1'b0;
    repeat (DRAIN + 2) @(negedge clk);
    chk(res_o == '0 && done_o == 1'b0, "R6 invalid steps ignored",
        longint'(res_o != '0), 0);
    run(5, 0);
    run(3, 0);          // R9: no start, sums continue
    do_start();
    run(1, 0);
    do_start();
    run(6, 3);          // R7: only tile 1 carries a weight exponent
    do_start();
    run(7, 2);          // R6: gaps with garbage between steps
    do_start();
    run(KMAX, 1);       // R8: worst-case magnitude over KMAX steps
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && cyc_q.size() == 0, "R4 every run completed",
        longint'(cyc_q.size()), 0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end
endmodule